// File: doc/BRIEF.md
# Aligned Free Thread-Slot Run Finder

This block keeps a bitmap of the hardware thread slots of one core and searches it for a run of free slots. Each bit of the bitmap marks one slot as in use. A launcher marks the threads of a new group busy through a set-range port. It frees them again through a clear-range port when the group retires.

Before a launch, the launcher asks for a run of S free slots, where S is the padded group size. The finder tests only start positions that are whole multiples of S, one position per clock, starting from slot 0. It returns the lowest aligned position whose S slots are all free, or it reports that no such position exists. The launcher then sets a range from that start. The count it sets is usually the unpadded thread count, so the padding slots stay free.

Top module: `slot_run_finder`

## Requirements
- R1: While reset is applied and right after it, every bit of `active_map` is 0 and `busy`, `done` and `found` are 0.
- R2: A cycle with `set_en` high makes slots `set_base` through `set_base+set_count-1` read 1 on `active_map` after the next clock edge. Positions past the last slot are dropped and do not wrap. All other slots keep their value.
- R3: A cycle with `clr_en` high makes slots `clr_base` through `clr_base+clr_count-1` read 0 after the next edge. If the set range and the clear range share a slot in the same cycle, that slot ends at 0.
- R4: A `search_start` sampled while idle, with a size S from 1 to SLOTS, raises `busy` after that edge. The finder tests candidate starts 0, S, 2S, … at one candidate per clock. If candidate number j succeeds, `done` is high with `found`=1 exactly j+1 clocks after the edge that sampled the start, and `busy` is low in that cycle.
- R5: A candidate succeeds only if all S slots from its start are 0 in `active_map`. The reported `run_base` is the lowest successful candidate.
- R6: A candidate whose run would go past slot SLOTS-1 is not tested. When no candidate succeeds, `done` rises with `found`=0 floor(SLOTS/S)+1 clocks after the start edge.
- R7: A start with size 0 or a size above SLOTS never raises `busy`. It gives `done`=1 with `found`=0 in the cycle right after the start edge.
- R8: `search_start` is ignored while `busy` is high. The running search keeps its result and its timing.
- R9: `found` and `run_base` keep their values from the `done` cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_en | input | 1 | Apply the set range this cycle |
| set_base | input | IDX_W | First slot to mark busy |
| set_count | input | SIZE_W | Number of slots to mark busy |
| clr_en | input | 1 | Apply the clear range this cycle |
| clr_base | input | IDX_W | First slot to free |
| clr_count | input | SIZE_W | Number of slots to free |
| search_start | input | 1 | Request a search (taken only when idle) |
| search_size | input | SIZE_W | Requested run length S (padded size) |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | The last search found a run |
| run_base | output | IDX_W | Start slot of the run found |
| active_map | output | SLOTS | Current slot bitmap, 1 = in use |

## Verification
The assertions check on every cycle the handshake rules and the register priority. `done` never coincides with `busy`, and a search never ends without `done`. Each reported start is aligned to S and fits inside the bitmap. Bad sizes end at once. A clear always beats a set, and a set with no clear always sticks. Which candidate is the lowest free one, and the exact cycle count for each map pattern, depend on the bitmap contents. Only the bench's vector table and directed cases can show those, together with the non-wrapping range edges and the result holding after completion.

// File: rtl/srf_pkg.sv
package srf_pkg;
   typedef enum logic {
      SC_IDLE = 1'b0,
      SC_SCAN = 1'b1
   } scan_state_t;
endpackage

// File: rtl/srf_range_mask.sv
module srf_range_mask #(
   parameter int N = 64,
   parameter int W = 8
) (
   input  logic         en,
   input  logic [W-1:0] base,
   input  logic [W-1:0] count,
   output logic [N-1:0] mask
);
   localparam int EW = W + 1;

   if (N < 1) begin : g_bad_n
      $error("srf_range_mask: N must be positive");
   end
   if ((2 ** W) <= N) begin : g_bad_w
      $error("srf_range_mask: W too narrow for N");
   end

   logic [EW-1:0] lo_ext;
   logic [EW-1:0] hi_ext;
   assign lo_ext = {1'b0, base};
   assign hi_ext = {1'b0, base} + {1'b0, count};

   for (genvar i = 0; i < N; i++) begin : g_bit
      localparam logic [EW-1:0] IPOS = EW'(i);
      assign mask[i] = en && (IPOS >= lo_ext) && (IPOS < hi_ext);
   end
endmodule

// File: rtl/srf_slot_map.sv
module srf_slot_map #(
   parameter int SLOTS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] set_mask,
   input  logic [SLOTS-1:0] clr_mask,
   output logic [SLOTS-1:0] map_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) map_q <= '0;
      else        map_q <= (map_q | set_mask) & ~clr_mask;
   end

   // R3: a cleared slot reads 0 on the next cycle, whatever the set range did
   assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((map_q & $past(clr_mask)) == '0));

   // R2: a slot set without a clear reads 1 on the next cycle
   assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((~map_q) & $past(set_mask & ~clr_mask)) == '0));
endmodule

// File: rtl/srf_scanner.sv
module srf_scanner
   import srf_pkg::*;
#(
   parameter int SLOTS = 64,
   parameter int CW    = 8,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CW-1:0]    size,
   input  logic             window_free,
   output logic [CW-1:0]    cand,
   output logic [CW-1:0]    size_q,
   output logic             busy,
   output logic             done,
   output logic             found,
   output logic [IDX_W-1:0] base
);
   scan_state_t state;
   logic        size_bad;
   logic        past_end;

   assign size_bad = (size == '0) || (size > CW'(SLOTS));
   assign past_end = (cand + size_q) > CW'(SLOTS);
   assign busy     = (state == SC_SCAN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SC_IDLE;
         cand   <= '0;
         size_q <= '0;
         done   <= 1'b0;
         found  <= 1'b0;
         base   <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            SC_IDLE: begin
               if (start) begin
                  found <= 1'b0;
                  if (size_bad) begin
                     done <= 1'b1;
                  end else begin
                     state  <= SC_SCAN;
                     cand   <= '0;
                     size_q <= size;
                  end
               end
            end
            SC_SCAN: begin
               if (past_end) begin
                  done  <= 1'b1;
                  found <= 1'b0;
                  state <= SC_IDLE;
               end else if (window_free) begin
                  done  <= 1'b1;
                  found <= 1'b1;
                  base  <= cand[IDX_W-1:0];
                  state <= SC_IDLE;
               end else begin
                  cand <= cand + size_q;
               end
            end
            default: state <= SC_IDLE;
         endcase
      end
   end

   // R4: completion is never reported while still scanning
   assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4: a scan never ends silently
   assert_scan_ends_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R5 / R6: a reported run is aligned and fits in the bitmap
   assert_aligned_fit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (((CW'(base) % size_q) == '0) &&
                           ((CW'(base) + size_q) <= CW'(SLOTS))));

   // R7: an unusable size completes at once, empty-handed
   assert_bad_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && size_bad) |=> (done && !found && !busy));

   // R8: a start during a scan changes nothing of the scan
   assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ((busy || done) && $stable(size_q)));

   // R9: the result holds while idle without a new start
   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(found) && $stable(base)));
endmodule

// File: rtl/slot_run_finder.sv
module slot_run_finder #(
   parameter int SLOTS  = 64,
   parameter int IDX_W  = $clog2(SLOTS),
   parameter int SIZE_W = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [IDX_W-1:0]  set_base,
   input  logic [SIZE_W-1:0] set_count,
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_base,
   input  logic [SIZE_W-1:0] clr_count,
   input  logic              search_start,
   input  logic [SIZE_W-1:0] search_size,
   output logic              busy,
   output logic              done,
   output logic              found,
   output logic [IDX_W-1:0]  run_base,
   output logic [SLOTS-1:0]  active_map
);
   localparam int CW = SIZE_W + 1;

   if (SLOTS < 2) begin : g_bad_slots
      $error("slot_run_finder: SLOTS must be at least 2");
   end
   if ((2 ** IDX_W) < SLOTS) begin : g_bad_idx
      $error("slot_run_finder: IDX_W too narrow");
   end
   if ((2 ** SIZE_W) <= SLOTS) begin : g_bad_size
      $error("slot_run_finder: SIZE_W too narrow");
   end

   logic [SLOTS-1:0] set_mask;
   logic [SLOTS-1:0] clr_mask;
   logic [SLOTS-1:0] win_mask;
   logic [CW-1:0]    cand;
   logic [CW-1:0]    size_q;
   logic             window_free;

   srf_range_mask #(.N(SLOTS), .W(CW)) u_set_rng (
      .en(set_en), .base(CW'(set_base)), .count(CW'(set_count)), .mask(set_mask));

   srf_range_mask #(.N(SLOTS), .W(CW)) u_clr_rng (
      .en(clr_en), .base(CW'(clr_base)), .count(CW'(clr_count)), .mask(clr_mask));

   srf_range_mask #(.N(SLOTS), .W(CW)) u_win_rng (
      .en(busy), .base(cand), .count(size_q), .mask(win_mask));

   srf_slot_map #(.SLOTS(SLOTS)) u_map (
      .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
      .map_q(active_map));

   assign window_free = ~|(active_map & win_mask);

   srf_scanner #(.SLOTS(SLOTS), .CW(CW), .IDX_W(IDX_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .start(search_start), .size(CW'(search_size)),
      .window_free(window_free), .cand(cand), .size_q(size_q), .busy(busy),
      .done(done), .found(found), .base(run_base));
endmodule

// File: tb/tb_slot_run_finder.sv
module tb_slot_run_finder;
   localparam int SLOTS  = 64;
   localparam int IDX_W  = 6;
   localparam int SIZE_W = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              set_en = 1'b0, clr_en = 1'b0, search_start = 1'b0;
   logic [IDX_W-1:0]  set_base = '0, clr_base = '0;
   logic [SIZE_W-1:0] set_count = '0, clr_count = '0, search_size = '0;
   logic              busy, done, found;
   logic [IDX_W-1:0]  run_base;
   logic [SLOTS-1:0]  active_map;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   slot_run_finder #(.SLOTS(SLOTS)) dut (
      .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_base(set_base),
      .set_count(set_count), .clr_en(clr_en), .clr_base(clr_base),
      .clr_count(clr_count), .search_start(search_start),
      .search_size(search_size), .busy(busy), .done(done), .found(found),
      .run_base(run_base), .active_map(active_map));

   typedef struct packed {
      logic [7:0] b1, c1, b2, c2, size;
      logic       fnd;
      logic [7:0] base, lat;
   } vec_t;

   // lat = clocks from the edge that samples the start to the done cycle
   localparam vec_t VECS [10] = '{
      '{8'd0,  8'd0,  8'd0, 8'd0,  8'd32, 1'b1, 8'd0,  8'd1},
      '{8'd0,  8'd4,  8'd0, 8'd0,  8'd8,  1'b1, 8'd8,  8'd2},
      '{8'd8,  8'd1,  8'd0, 8'd1,  8'd8,  1'b1, 8'd16, 8'd3},
      '{8'd0,  8'd64, 8'd0, 8'd0,  8'd1,  1'b0, 8'd0,  8'd65},
      '{8'd0,  8'd63, 8'd0, 8'd0,  8'd1,  1'b1, 8'd63, 8'd64},
      '{8'd1,  8'd1,  8'd0, 8'd0,  8'd3,  1'b1, 8'd3,  8'd2},
      '{8'd10, 8'd30, 8'd0, 8'd0,  8'd24, 1'b0, 8'd0,  8'd3},
      '{8'd40, 8'd24, 8'd0, 8'd1,  8'd20, 1'b1, 8'd20, 8'd2},
      '{8'd63, 8'd1,  8'd0, 8'd0,  8'd64, 1'b0, 8'd0,  8'd2},
      '{8'd60, 8'd10, 8'd0, 8'd60, 8'd4,  1'b0, 8'd0,  8'd17}
   };

   task automatic check(input logic ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_set(input int b, input int c);
      @(negedge clk);
      set_en = 1'b1; set_base = IDX_W'(b); set_count = SIZE_W'(c);
      @(negedge clk);
      set_en = 1'b0;
   endtask

   task automatic do_clr(input int b, input int c);
      @(negedge clk);
      clr_en = 1'b1; clr_base = IDX_W'(b); clr_count = SIZE_W'(c);
      @(negedge clk);
      clr_en = 1'b0;
   endtask

   // returns the number of clocks after the start edge until done is seen
   task automatic do_search(input int s, output int lat);
      int n;
      @(negedge clk);
      search_start = 1'b1; search_size = SIZE_W'(s);
      @(negedge clk);
      search_start = 1'b0;
      n = 0;
      while (!done && n < 300) begin
         @(negedge clk);
         n++;
      end
      lat = n;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(active_map == '0, "R1 map", active_map, 0);
      check(!busy && !done && !found, "R1 flags", {busy, done, found}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(active_map == '0 && !busy && !done && !found, "R1 after release",
            {active_map[3:0], busy, done, found}, 0);

      // R4 R5 R6: vector table
      foreach (VECS[i]) begin
         do_clr(0, SLOTS);
         if (VECS[i].c1 != 0) do_set(VECS[i].b1, VECS[i].c1);
         if (VECS[i].c2 != 0) do_set(VECS[i].b2, VECS[i].c2);
         do_search(VECS[i].size, lat);
         check(done == 1'b1, $sformatf("R4 vec%0d done", i), done, 1);
         check(found == VECS[i].fnd, $sformatf("R6 vec%0d found", i), found, VECS[i].fnd);
         if (VECS[i].fnd)
            check(run_base == VECS[i].base[IDX_W-1:0], $sformatf("R5 vec%0d base", i),
                  run_base, VECS[i].base);
         check(lat == VECS[i].lat, $sformatf("R4 vec%0d latency", i), lat, VECS[i].lat);
         check(!busy, $sformatf("R4 vec%0d busy low at done", i), busy, 0);
      end

      // R2: range past the top is dropped, no wrap
      do_clr(0, SLOTS);
      do_set(60, 10);
      check(active_map == 64'hF000_0000_0000_0000, "R2 top clip", active_map,
            64'hF000_0000_0000_0000);
      do_set(2, 3);
      check(active_map == 64'hF000_0000_0000_001C, "R2 add range", active_map,
            64'hF000_0000_0000_001C);

      // R3: clear range, and clear beats set on overlap
      do_clr(61, 2);
      check(active_map == 64'h9000_0000_0000_001C, "R3 clear range", active_map,
            64'h9000_0000_0000_001C);
      do_clr(0, SLOTS);
      @(negedge clk);
      set_en = 1'b1; set_base = 6'd0; set_count = 7'd8;
      clr_en = 1'b1; clr_base = 6'd4; clr_count = 7'd8;
      @(negedge clk);
      set_en = 1'b0; clr_en = 1'b0;
      check(active_map == 64'h0F, "R3 clear wins", active_map, 64'h0F);

      // R7: unusable sizes
      do_search(0, lat);
      check(done && !found && lat == 0, "R7 size zero", {done, found, 8'(lat)}, 10'h200);
      @(negedge clk);
      search_start = 1'b1; search_size = 7'd65;
      @(negedge clk);
      search_start = 1'b0;
      check(done && !found && !busy, "R7 size too big", {done, found, busy}, 3'b100);

      // R8: start during a scan is ignored; R9: result holds afterwards
      do_clr(0, SLOTS);
      do_set(0, 56);
      @(negedge clk);
      search_start = 1'b1; search_size = 7'd8;
      @(negedge clk);
      search_start = 1'b0;
      lat = 0;
      @(negedge clk); lat++;
      @(negedge clk); lat++;
      search_start = 1'b1; search_size = 7'd1;
      @(negedge clk); lat++;
      search_start = 1'b0;
      while (!done && lat < 300) begin
         @(negedge clk);
         lat++;
      end
      check(found && run_base == 6'd56, "R8 result kept", run_base, 56);
      check(lat == 8, "R8 latency kept", lat, 8);
      repeat (3) @(negedge clk);
      check(found && run_base == 6'd56 && !done, "R9 hold", {found, run_base}, {1'b1, 6'd56});

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule